// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates addresses for one port of a multi-port memory. It keeps a burst counter and a mask register. On every clock edge it carries out exactly one counter operation: load, increment, readback or hold. The operation is chosen from a set of active-low controls by a fixed priority. A separate active-low control writes the mask register, and that write is independent of the counter operation.

The mask is a contiguous run of ones that starts at bit 0. It names the counter bits that an increment may change. An increment therefore wraps to zero inside a power-of-two window, and every bit above the window stays frozen. When the mask is all ones, the window covers the whole address space.

A readback places either the counter or the mask on the address bus for one cycle, and the counter does not move in that cycle. If the port's chip enables are active during a readback, the block also asks for the data bus to be tri-stated. The chip enables have no other effect.

Top module: `masked_burst_counter`

## Requirements
- R1: A synchronous reset (`rst` high) clears the counter to 0 and sets the mask to all ones. After reset, `addr_oe` and `data_hiz` are both low.
- R2: When `load_n` is low at a rising edge, the counter takes `addr_in`. Load has the highest priority of all counter operations.
- R3: When `load_n` is high and `inc_n` is low at a rising edge, the counter advances by one.
- R4: An increment changes only the counter bits where the mask is 1. When those bits are all ones, they wrap to zero while the bits above the window keep their values. With a full mask, the counter wraps from all ones to 0.
- R5: When `load_n` and `inc_n` are high and `cnt_rd_n` is low at an edge, then after that edge `addr_oe` is 1 and `addr_out` holds the counter value from before the edge. The counter does not change in that cycle.
- R6: When `msk_rd_n` is the only low counter control at an edge, then after that edge `addr_oe` is 1 and `addr_out` holds the mask. If `cnt_rd_n` and `msk_rd_n` are both low, the counter is read.
- R7: `addr_oe` is high for exactly the one cycle that follows each edge at which a readback was selected, and it is low after any other edge.
- R8: `data_hiz` goes high together with `addr_oe` when the chip enables were active (`ce0_n` low and `ce1` high) at the readback edge. Otherwise `data_hiz` stays low.
- R9: When `load_n`, `inc_n`, `cnt_rd_n` and `msk_rd_n` are all high, the counter holds its value.
- R10: When `msk_ld_n` is low at an edge, the mask takes the run of ones in `addr_in` that starts at bit 0, up to the first zero bit. For example, 0x2F stores 0x0F and 0xFE stores 0x00. The mask write happens alongside any counter operation.
- R11: The chip enables have no effect on the load, increment, hold or mask operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Load counter from `addr_in`, active low |
| inc_n | input | 1 | Increment counter, active low |
| cnt_rd_n | input | 1 | Counter readback request, active low |
| msk_rd_n | input | 1 | Mask readback request, active low |
| msk_ld_n | input | 1 | Write mask from `addr_in`, active low |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| addr_in | input | AW | Address bus input value |
| addr_out | output | AW | Value driven onto the address bus during readback |
| addr_oe | output | 1 | Address bus output enable |
| data_hiz | output | 1 | Request to tri-state the data bus |

## Verification
The hardest case to reach is a wrap inside a narrow window. The counter's upper bits must be set to a non-zero pattern that has to survive the wrap, and the mask must hold a value narrower than its reset value. The stimulus first loads a non-contiguous pattern into the mask, which checks how the stored run is trimmed. It then loads the counter with the low window bits one step short of all ones and increments across the boundary. After each step it reads the counter back, so the frozen upper bits and the zeroed window are both visible at the ports.

// File: rtl/masked_burst_counter.sv
module masked_burst_counter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          inc_n,
  input  logic          cnt_rd_n,
  input  logic          msk_rd_n,
  input  logic          msk_ld_n,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic          data_hiz
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cnt, mask, mask_in, cnt_inc;

  wire do_load = !load_n;
  wire do_inc  = load_n && !inc_n;
  wire do_crd  = load_n && inc_n && !cnt_rd_n;
  wire do_mrd  = load_n && inc_n && cnt_rd_n && !msk_rd_n;
  wire do_rd   = do_crd || do_mrd;
  wire ce_on   = !ce0_n && ce1;

  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < AW; i++) begin
      run = run & addr_in[i];
      mask_in[i] = run;
    end
  end

  assign cnt_inc = (cnt & ~mask) | ((cnt + ONE) & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      mask     <= '1;
      addr_oe  <= 1'b0;
      data_hiz <= 1'b0;
      addr_out <= '0;
    end else begin
      if (do_load)     cnt <= addr_in;
      else if (do_inc) cnt <= cnt_inc;
      if (!msk_ld_n) mask <= mask_in;
      addr_oe  <= do_rd;
      data_hiz <= do_rd && ce_on;
      if (do_crd)      addr_out <= cnt;
      else if (do_mrd) addr_out <= mask;
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> cnt == $past(addr_in));

  // R4
  frozen_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !inc_n && msk_ld_n) |=> ((cnt & ~mask) == $past(cnt & ~mask)));

  // R4
  window_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !inc_n && msk_ld_n && ((cnt & mask) == mask)) |=> ((cnt & mask) == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && inc_n) |=> $stable(cnt));

  // R7
  oe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && inc_n && (!cnt_rd_n || !msk_rd_n)) |=> addr_oe);

  // R7
  oe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !(load_n && inc_n && (!cnt_rd_n || !msk_rd_n)) |=> !addr_oe);

  // R8
  hiz_with_oe_chk: assert property (@(posedge clk) disable iff (rst)
    data_hiz |-> addr_oe);

  // R10
  mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
    ((mask & (mask + ONE)) == '0));

endmodule

// File: tb/masked_burst_counter_tb.sv
module masked_burst_counter_tb;
  localparam int AW = 8;

  logic clk = 0, rst = 1;
  logic load_n = 1, inc_n = 1, cnt_rd_n = 1, msk_rd_n = 1, msk_ld_n = 1;
  logic ce0_n = 1, ce1 = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic addr_oe, data_hiz;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  masked_burst_counter #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .load_n(load_n), .inc_n(inc_n), .cnt_rd_n(cnt_rd_n),
    .msk_rd_n(msk_rd_n), .msk_ld_n(msk_ld_n), .ce0_n(ce0_n), .ce1(ce1),
    .addr_in(addr_in), .addr_out(addr_out), .addr_oe(addr_oe), .data_hiz(data_hiz));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    load_n = 1; inc_n = 1; cnt_rd_n = 1; msk_rd_n = 1; msk_ld_n = 1;
  endtask

  task automatic load(logic [AW-1:0] v);
    idle(); load_n = 0; addr_in = v; step(); idle();
  endtask

  task automatic mload(logic [AW-1:0] v);
    idle(); msk_ld_n = 0; addr_in = v; step(); idle();
  endtask

  task automatic inc(int n);
    idle();
    for (int i = 0; i < n; i++) begin inc_n = 0; step(); end
    idle();
  endtask

  task automatic rd_cnt(string req, logic [AW-1:0] exp);
    idle(); cnt_rd_n = 0; step();
    chk(req, addr_oe, 1); chk(req, addr_out, exp);
    idle(); step();
    chk("R7", addr_oe, 0);
  endtask

  task automatic rd_msk(string req, logic [AW-1:0] exp);
    idle(); msk_rd_n = 0; step();
    chk(req, addr_oe, 1); chk(req, addr_out, exp);
    idle(); step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1", addr_oe, 0); chk("R1", data_hiz, 0);
    rd_cnt("R1", 8'h00);
    rd_msk("R1", 8'hFF);
  endtask

  task automatic t_load();
    load(8'h5A); rd_cnt("R2", 8'h5A);
    idle(); load_n = 0; inc_n = 0; cnt_rd_n = 0; addr_in = 8'h33; step();
    chk("R2", addr_oe, 0);
    idle(); rd_cnt("R2", 8'h33);
  endtask

  task automatic t_inc();
    load(8'h10); inc(3); rd_cnt("R3", 8'h13);
    load(8'hFF); inc(1); rd_cnt("R4", 8'h00);
  endtask

  task automatic t_wrap();
    mload(8'h2F); rd_msk("R10", 8'h0F);
    mload(8'h07); rd_msk("R10", 8'h07);
    load(8'hA6); inc(1); rd_cnt("R4", 8'hA7);
    inc(1); rd_cnt("R4", 8'hA0);
    inc(9); rd_cnt("R4", 8'hA1);
    mload(8'hFE); rd_msk("R10", 8'h00);
    inc(4); rd_cnt("R4", 8'hA1);
    idle(); inc_n = 0; msk_ld_n = 0; addr_in = 8'hFF; step(); idle();
    rd_cnt("R10", 8'hA1);
    rd_msk("R10", 8'hFF);
  endtask

  task automatic t_readback();
    load(8'h42); mload(8'h1F);
    idle(); cnt_rd_n = 0; msk_rd_n = 0; step();
    chk("R6", addr_out, 8'h42);
    idle(); step(); chk("R7", addr_oe, 0);
    rd_msk("R6", 8'h1F);
    idle(); cnt_rd_n = 0; step(); step();
    chk("R7", addr_oe, 1); chk("R5", addr_out, 8'h42);
    idle(); step();
    rd_cnt("R5", 8'h42);
  endtask

  task automatic t_hiz();
    ce0_n = 0; ce1 = 1;
    idle(); cnt_rd_n = 0; step(); chk("R8", data_hiz, 1);
    idle(); step(); chk("R8", data_hiz, 0);
    ce0_n = 0; ce1 = 0;
    idle(); msk_rd_n = 0; step(); chk("R8", data_hiz, 0); chk("R8", addr_oe, 1);
    idle(); step();
    ce0_n = 1; ce1 = 1;
    idle(); cnt_rd_n = 0; step(); chk("R8", data_hiz, 0);
    idle(); step();
  endtask

  task automatic t_hold_ce();
    mload(8'hFF); load(8'h77);
    idle(); for (int i = 0; i < 5; i++) step();
    rd_cnt("R9", 8'h77);
    ce0_n = 0; ce1 = 1;
    load(8'h20); inc(2); rd_cnt("R11", 8'h22);
    mload(8'h03); inc(2); rd_cnt("R11", 8'h20);
    ce0_n = 1; ce1 = 0;
    inc(1); rd_cnt("R11", 8'h21);
    rd_msk("R11", 8'h03);
  endtask

  initial begin
    #180000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_load();
    t_inc();
    t_wrap();
    t_readback();
    t_hiz();
    t_hold_ce();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule